// File: doc/BRIEF.md
# Serial-Programmed Synthesizer Control Register Bank

This block holds the control settings of a frequency synthesizer and is loaded through a three-wire serial port that has a serial clock, a data line and a latch line. The three serial inputs are first synchronised into the system clock domain. A 24-bit shift register collects data bits on the rising edges of the serial clock. On the rising edge of the latch line, the word held in the shift register is decoded. Its three least significant bits select the register that receives the word.

Three registers exist. The frequency register holds an integer value and a fractional value. The phase register holds a seed phase word. The divider register holds a reference divider, a set of option bits and a charge-pump boost bit. Writes to the phase register and to the divider register land only in a shadow copy, so the settings in use stay exactly as they were. When the frequency register is latched, both shadow copies and the new frequency value become active together in one system clock cycle. In that same cycle a single-cycle commit pulse tells downstream logic that a new setting is in force. Software programs the phase register first, then the divider register, and writes the frequency register last. The latch of that last word can be held back until the moment the frequency switch is wanted.

Top module: `synth_regbank`

## Requirements
- R1: After reset every output is zero: frequency fields, phase word, reference divider, option bits and charge-pump boost. The commit pulse is low.
- R2: Data bits are taken MSB first on rising serial clock edges. On a rising latch edge the last 24 bits received form the word. Bits [2:0] give the address: 0 selects frequency, 1 selects divider, 2 selects phase.
- R3: A latched frequency word drives bits [23:12] onto the integer output and bits [11:3] onto the fractional output.
- R4: A latched phase word stores bits [23:3] in the phase shadow only. The phase output stays unchanged until the next frequency latch.
- R5: A latched divider word stores its payload in the divider shadow only. After the next frequency latch, bits [12:3] appear as the reference divider, bits [22:13] as the option bits and bit 23 as the charge-pump boost.
- R6: On a frequency latch, the frequency, phase and divider outputs all take their new values in the same clock cycle as the commit pulse.
- R7: The commit pulse is high for exactly one clock cycle for each frequency latch. It never rises for a phase, divider or undefined write.
- R8: A word with address 3 to 7 is ignored. No output changes, and both shadow copies keep their contents.
- R9: Serial bits shifted before the final 24 have no effect. Nothing changes while the latch line stays low, however long the shifting goes on.
- R10: A second write to a shadow register before the commit replaces the first, so the last value written is the one that becomes active.
- R11: Shadow contents are kept after a commit. A frequency latch with no new secondary writes makes the same phase and divider values active again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, MSB first |
| ser_latch | input | 1 | Serial latch; rising edge captures the word |
| freq_int | output | 12 | Active integer value |
| freq_frac | output | 9 | Active fractional value |
| phase_word | output | 21 | Active phase seed |
| ref_div | output | 10 | Active reference divider |
| cp_adj | output | 1 | Active charge-pump boost |
| div_opts | output | 10 | Active divider option bits |
| commit | output | 1 | One-cycle pulse when new settings take effect |

## Verification
The bench drives plain frequency writes, and it checks the commit that follows each of them as well as the outputs that stay put. This separates the direct path from the deferred path. The bench also sends phase and divider words followed by a frequency word. Checking the outputs both before and at the commit tells a true shadow from a write that goes straight to the output. Undefined addresses, repeated shadow writes, over-long bit streams and back-to-back frequency latches each separate a correct decoder and buffer from one that leaks, keeps stale values or keeps the wrong bits.

// File: rtl/synth_regbank.sv
module synth_regbank #(
  parameter int WORD_W = 24,
  parameter int ADDR_W = 3,
  parameter int INT_W  = 12,
  parameter int REF_W  = 10
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             ser_clk,
  input  logic                             ser_data,
  input  logic                             ser_latch,
  output logic [INT_W-1:0]                 freq_int,
  output logic [WORD_W-ADDR_W-INT_W-1:0]   freq_frac,
  output logic [WORD_W-ADDR_W-1:0]         phase_word,
  output logic [REF_W-1:0]                 ref_div,
  output logic                             cp_adj,
  output logic [WORD_W-ADDR_W-REF_W-2:0]   div_opts,
  output logic                             commit
);

  localparam int PAY_W = WORD_W - ADDR_W;
  localparam int FRAC_W = PAY_W - INT_W;
  localparam int OPT_W = PAY_W - REF_W - 1;
  localparam logic [ADDR_W-1:0] ADR_FREQ  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_DIV   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_PHASE = ADDR_W'(2);

  logic [2:0]        sck_s, sle_s;
  logic [1:0]        sdt_s;
  logic [WORD_W-1:0] shreg;
  logic [PAY_W-1:0]  phase_sh, div_sh;
  logic [PAY_W-1:0]  freq_act, phase_act, div_act;
  logic              commit_q;

  wire sck_rise = sck_s[1] & ~sck_s[2];
  wire le_rise  = sle_s[1] & ~sle_s[2];
  wire [ADDR_W-1:0] addr    = shreg[ADDR_W-1:0];
  wire [PAY_W-1:0]  payload = shreg[WORD_W-1:ADDR_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_s <= '0;
      sle_s <= '0;
      sdt_s <= '0;
      shreg <= '0;
    end else begin
      sck_s <= {sck_s[1:0], ser_clk};
      sle_s <= {sle_s[1:0], ser_latch};
      sdt_s <= {sdt_s[0], ser_data};
      if (sck_rise) shreg <= {shreg[WORD_W-2:0], sdt_s[1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_sh  <= '0;
      div_sh    <= '0;
      freq_act  <= '0;
      phase_act <= '0;
      div_act   <= '0;
      commit_q  <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (le_rise) begin
        case (addr)
          ADR_FREQ: begin
            freq_act  <= payload;
            phase_act <= phase_sh;
            div_act   <= div_sh;
            commit_q  <= 1'b1;
          end
          ADR_PHASE: phase_sh <= payload;
          ADR_DIV:   div_sh   <= payload;
          default: ;
        endcase
      end
    end
  end

  assign freq_int   = freq_act[PAY_W-1:FRAC_W];
  assign freq_frac  = freq_act[FRAC_W-1:0];
  assign phase_word = phase_act;
  assign cp_adj     = div_act[PAY_W-1];
  assign div_opts   = div_act[PAY_W-2:REF_W];
  assign ref_div    = div_act[REF_W-1:0];
  assign commit     = commit_q;

  // R4, R6: the active phase moves only together with a commit
  a_r4_phase_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_act) |-> commit_q);
  // R5, R6: the active divider moves only together with a commit
  a_r5_div_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_act) |-> commit_q);
  // R3: the active frequency moves only together with a commit
  a_r3_freq_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(freq_act) |-> commit_q);
  // R7: the commit pulse lasts a single cycle
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |=> !commit_q);
  // R7: a commit comes only from a word addressed to the frequency register
  a_r7_freq_source: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> $past(addr) == ADR_FREQ);
  // R8: the phase shadow is loaded only by a phase address
  a_r8_phase_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_sh) |-> $past(addr) == ADR_PHASE);
  // R8: the divider shadow is loaded only by a divider address
  a_r8_div_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_sh) |-> $past(addr) == ADR_DIV);

endmodule

// File: tb/sim_synth_regbank.sv
`timescale 1ns/1ps
module sim_synth_regbank;
  logic clk = 0, rst_n = 0, sclk = 0, sdat = 0, sle = 0;
  logic [11:0] f_int;
  logic [8:0]  f_frac;
  logic [20:0] ph;
  logic [9:0]  rdiv, opts;
  logic        cpa, cmt;
  int checks = 0, errors = 0, ncommit = 0;
  logic [11:0] snap_int;
  logic [20:0] snap_ph;
  logic [9:0]  snap_rdiv;
  logic        snap_cpa;

  always #5 clk = ~clk;

  synth_regbank u0 (.clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_data(sdat),
    .ser_latch(sle), .freq_int(f_int), .freq_frac(f_frac), .phase_word(ph),
    .ref_div(rdiv), .cp_adj(cpa), .div_opts(opts), .commit(cmt));

  always @(negedge clk) if (cmt) begin
    ncommit++;
    snap_int = f_int; snap_ph = ph; snap_rdiv = rdiv; snap_cpa = cpa;
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(logic [31:0] v, int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat = v[i]; wclk(3);
      sclk = 1;    wclk(3);
      sclk = 0;    wclk(3);
    end
  endtask

  task automatic latch();
    sle = 1; wclk(3);
    sle = 0; wclk(6);
  endtask

  task automatic send(logic [23:0] w);
    shift_bits({8'h0, w}, 24);
    latch();
  endtask

  function automatic logic [23:0] wfreq(logic [11:0] i, logic [8:0] f);
    return {i, f, 3'd0};
  endfunction
  function automatic logic [23:0] wdiv(logic c, logic [9:0] o, logic [9:0] r);
    return {c, o, r, 3'd1};
  endfunction
  function automatic logic [23:0] wph(logic [20:0] p);
    return {p, 3'd2};
  endfunction

  task automatic t_reset();
    chk("R1 int", f_int, 0); chk("R1 frac", f_frac, 0); chk("R1 phase", ph, 0);
    chk("R1 refdiv", rdiv, 0); chk("R1 cpadj", cpa, 0); chk("R1 opts", opts, 0);
    chk("R1 commit", cmt, 0); chk("R1 no commits", ncommit, 0);
  endtask

  task automatic t_freq_basic();
    int c0 = ncommit;
    send(wfreq(12'hA5C, 9'h13B));
    chk("R3 int", f_int, 12'hA5C); chk("R3 frac", f_frac, 9'h13B);
    chk("R2 MSB first", f_int[11], 1'b1);
    chk("R7 one commit", ncommit - c0, 1);
    send(wfreq(12'h001, 9'h1FF));
    chk("R3 int 2", f_int, 12'h001); chk("R3 frac 2", f_frac, 9'h1FF);
  endtask

  task automatic t_deferred();
    int c0 = ncommit;
    send(wph(21'h15A3C7));
    chk("R4 phase held", ph, 0);
    send(wdiv(1'b1, 10'h2B4, 10'h05D));
    chk("R5 refdiv held", rdiv, 0); chk("R5 cpadj held", cpa, 0);
    chk("R5 opts held", opts, 0); chk("R4 phase still held", ph, 0);
    chk("R7 no commit on secondary", ncommit - c0, 0);
    send(wfreq(12'h321, 9'h0AA));
    chk("R4 phase active", ph, 21'h15A3C7);
    chk("R5 refdiv active", rdiv, 10'h05D); chk("R5 cpadj active", cpa, 1);
    chk("R5 opts active", opts, 10'h2B4);
    chk("R7 one commit", ncommit - c0, 1);
    chk("R6 int at commit", snap_int, 12'h321);
    chk("R6 phase at commit", snap_ph, 21'h15A3C7);
    chk("R6 refdiv at commit", snap_rdiv, 10'h05D);
    chk("R6 cpadj at commit", snap_cpa, 1);
  endtask

  task automatic t_undefined();
    int c0 = ncommit;
    for (int a = 3; a < 8; a++) begin
      send({21'h1FFFFF, 3'(a)});
      chk("R8 int", f_int, 12'h321); chk("R8 phase", ph, 21'h15A3C7);
      chk("R8 refdiv", rdiv, 10'h05D);
    end
    chk("R8 no commit", ncommit - c0, 0);
    send(wfreq(12'h322, 9'h0AB));
    chk("R8 phase shadow kept", ph, 21'h15A3C7);
    chk("R8 div shadow kept", opts, 10'h2B4);
  endtask

  task automatic t_last_wins();
    send(wph(21'h000111)); send(wph(21'h0ABCDE));
    send(wdiv(1'b1, 10'h111, 10'h222)); send(wdiv(1'b0, 10'h0F0, 10'h00F));
    send(wfreq(12'h400, 9'h001));
    chk("R10 phase last", ph, 21'h0ABCDE);
    chk("R10 refdiv last", rdiv, 10'h00F); chk("R10 cpadj last", cpa, 0);
    chk("R10 opts last", opts, 10'h0F0);
  endtask

  task automatic t_long_stream();
    int c0 = ncommit;
    shift_bits(32'hFFFF_FFFF, 20);
    wclk(20);
    chk("R9 held while latch low", f_int, 12'h400);
    shift_bits({8'h0, wfreq(12'h7E1, 9'h055)}, 24);
    wclk(40);
    chk("R9 still held", f_int, 12'h400);
    chk("R9 no commit before latch", ncommit - c0, 0);
    latch();
    chk("R9 last 24 bits int", f_int, 12'h7E1);
    chk("R9 last 24 bits frac", f_frac, 9'h055);
  endtask

  task automatic t_recommit();
    int c0 = ncommit;
    send(wfreq(12'h0F0, 9'h100));
    send(wfreq(12'h0F1, 9'h101));
    chk("R11 phase kept", ph, 21'h0ABCDE);
    chk("R11 refdiv kept", rdiv, 10'h00F);
    chk("R11 opts kept", opts, 10'h0F0);
    chk("R7 two commits", ncommit - c0, 2);
  endtask

  initial begin
    wclk(5);
    rst_n = 1;
    wclk(5);
    t_reset();
    t_freq_basic();
    t_deferred();
    t_undefined();
    t_last_wins();
    t_long_stream();
    t_recommit();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    checks++; errors++;
    $display("FAIL watchdog expired got 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule